// File: doc/BRIEF.md
# Safe-Frequency Fallback Sequencer

This block steers a multi-PLL clock generator into a known-good operating point when an external agent asks for it. It watches an active-low fallback request and acts only on the high-to-low transition of that request. On that transition it captures a safe frequency word and drives it onto the frequency-select output that fans out to every PLL. It then holds the clock-output enable low while the PLLs relock. The outputs come back either when a fresh lock indication is seen or when a bounded number of millisecond ticks has elapsed, whichever happens first.

The safe word is a built-in power-on default until software has written either byte of a two-byte safe-frequency register. From then on, the register contents are used. Once the outputs are back on, the block times how long they have been stable. If the request is released before the required settling time, it raises an early-release status flag. A timeout status flag records a forced re-enable. While no fallback is active, the frequency-select output simply follows the normal run-time selection.

Top module: `safe_freq_fallback`

## Requirements
- R1: After power-on reset (`rst_n` low), `clk_oe` is 1, `fsel` equals `run_fsel`, and `status_timeout` and `status_early` are 0.
- R2: A 1-to-0 transition on `rst_req_n` starts a fallback. `clk_oe` is 0 at the second rising clock edge after the transition. Holding `rst_req_n` low afterwards starts nothing further.
- R3: While the outputs are gated, `fsel` carries the safe word that was captured at the starting transition.
- R4: The outputs stay gated for at most OFF_MS (default 4) `ms_tick` pulses. If no fresh lock has arrived, the OFF_MS-th tick re-enables the outputs and sets `status_timeout`.
- R5: The safe word is DEFAULT_FSEL (default 16'h0A5C) until a write strobe has been seen. `safe_wr[0]` marks a write of the low byte and `safe_wr[1]` a write of the high byte. After that, the safe word is `{safe_hi, safe_lo}`, with `safe_hi` in bits 15:8 and `safe_lo` in bits 7:0. The written flag is cleared only by `rst_n`.
- R6: Changes to `safe_hi`, `safe_lo` or `safe_wr` after the starting transition do not alter `fsel` during that fallback.
- R7: While gated, `pll_locked` sampled high after having been sampled low since the starting transition re-enables the outputs one edge later, without setting `status_timeout`. This takes priority over a tick arriving in the same cycle. A lock that never dropped does not re-enable the outputs.
- R8: After re-enable, `fsel` keeps the safe word until `rst_req_n` is sampled high. Two edges after it rises, `fsel` follows `run_fsel` again.
- R9: `status_early` is set if `rst_req_n` rises while the outputs are gated, or after fewer than STABLE_MS (default 2) ticks of re-enabled output. It is not set after STABLE_MS or more ticks. Both status flags clear at the next starting transition.
- R10: A new 1-to-0 transition during an active fallback restarts it. The outputs are gated again, the tick count restarts from zero, and both status flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| rst_req_n | input | 1 | Active-low fallback request, acted on at its falling transition |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| pll_locked | input | 1 | Combined PLL lock indication |
| safe_wr | input | 2 | Write strobes for the safe register: bit 0 low byte, bit 1 high byte |
| safe_lo | input | 8 | Safe register low byte |
| safe_hi | input | 8 | Safe register high byte |
| run_fsel | input | 16 | Normal operating frequency select |
| fsel | output | 16 | Frequency select driven to all PLLs |
| clk_oe | output | 1 | Clock output enable |
| status_timeout | output | 1 | Last re-enable was forced by the tick limit |
| status_early | output | 1 | Request released before the outputs were stable long enough |

## Verification
A wrong sequencer state appears on `clk_oe` and `fsel` within two edges of the starting transition. It also appears at the very tick or lock sample that should end the gated window: the enable either comes back one tick early or late, or stays low. A stale or wrongly chosen safe word shows on `fsel` as soon as the gate closes. A miscounted settling time stays hidden until the request is released. Only then does `status_early` read wrong, two edges later, so the bench releases at hold times on both sides of the limit.

// File: rtl/sff_pkg.sv
package sff_pkg;
  localparam int BYTE_W = 8;
  localparam int FSEL_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_GATE = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_e;

  // Safe word choice: programmed bytes once written, else the built-in default.
  function automatic logic [FSEL_W-1:0] pick_safe(
    input logic              written,
    input logic [BYTE_W-1:0] hi,
    input logic [BYTE_W-1:0] lo,
    input logic [FSEL_W-1:0] dflt
  );
    return written ? {hi, lo} : dflt;
  endfunction

  // Release counts as premature when fewer settled ticks than required were seen.
  function automatic logic release_too_soon(input int unsigned ticks, input int unsigned need);
    return ticks < need;
  endfunction
endpackage

// File: rtl/sff_edge_det.sv
module sff_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic req_lvl,
  output logic fall,
  output logic rise
);
  logic smp_q, smp_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      smp_qq <= 1'b0;
    end else begin
      smp_q  <= req_n;
      smp_qq <= smp_q;
    end
  end

  assign req_lvl = smp_q;
  assign fall    = smp_qq & ~smp_q;
  assign rise    = ~smp_qq & smp_q;
endmodule

// File: rtl/sff_safe_store.sv
module sff_safe_store #(
  parameter int NUM_BYTES = 2,
  parameter logic [sff_pkg::FSEL_W-1:0] DEFAULT_FSEL = 16'h0A5C
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BYTES-1:0]        wr_strobe,
  input  logic [sff_pkg::BYTE_W-1:0]  byte_lo,
  input  logic [sff_pkg::BYTE_W-1:0]  byte_hi,
  output logic                        written,
  output logic [sff_pkg::FSEL_W-1:0]  safe_word
);
  logic written_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          written_q <= 1'b0;
    else if (|wr_strobe) written_q <= 1'b1;
  end

  assign written   = written_q;
  assign safe_word = sff_pkg::pick_safe(written_q, byte_hi, byte_lo, DEFAULT_FSEL);
endmodule

// File: rtl/sff_seq_fsm.sv
module sff_seq_fsm #(
  parameter int OFF_MS    = 4,
  parameter int STABLE_MS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fall,
  input  logic                       rise,
  input  logic                       req_lvl,
  input  logic                       ms_tick,
  input  logic                       pll_locked,
  input  logic [sff_pkg::FSEL_W-1:0] safe_word,
  input  logic [sff_pkg::FSEL_W-1:0] run_fsel,
  output logic [sff_pkg::FSEL_W-1:0] fsel,
  output logic                       clk_oe,
  output logic                       status_timeout,
  output logic                       status_early,
  output logic                       lock_dip,
  output logic                       in_gate
);
  import sff_pkg::*;

  localparam int OFF_CW  = $clog2(OFF_MS + 1);
  localparam int STAB_CW = $clog2(STABLE_MS + 1);
  localparam logic [OFF_CW-1:0]  OFF_LAST = OFF_CW'(OFF_MS - 1);
  localparam logic [STAB_CW-1:0] STAB_MAX = STAB_CW'(STABLE_MS);

  seq_state_e           state;
  logic [OFF_CW-1:0]    off_cnt;
  logic [STAB_CW-1:0]   stab_cnt;
  logic                 dip_q, to_q, early_q;
  logic [FSEL_W-1:0]    safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      off_cnt  <= '0;
      stab_cnt <= '0;
      dip_q    <= 1'b0;
      to_q     <= 1'b0;
      early_q  <= 1'b0;
      safe_q   <= '0;
    end else if (fall) begin
      // A new request transition always (re)starts the fallback.
      state   <= ST_GATE;
      off_cnt <= '0;
      dip_q   <= 1'b0;
      to_q    <= 1'b0;
      early_q <= 1'b0;
      safe_q  <= safe_word;
    end else begin
      case (state)
        ST_GATE: begin
          if (rise)        early_q <= 1'b1;
          if (!pll_locked) dip_q   <= 1'b1;
          if (dip_q && pll_locked) begin
            state    <= ST_HOLD;
            stab_cnt <= '0;
          end else if (ms_tick) begin
            if (off_cnt == OFF_LAST) begin
              state    <= ST_HOLD;
              stab_cnt <= '0;
              to_q     <= 1'b1;
            end else begin
              off_cnt <= off_cnt + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (req_lvl) begin
            early_q <= early_q | release_too_soon(32'(stab_cnt), 32'(STABLE_MS));
            state   <= ST_RUN;
          end else if (ms_tick && stab_cnt != STAB_MAX) begin
            stab_cnt <= stab_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign in_gate        = (state == ST_GATE);
  assign clk_oe         = !in_gate;
  assign fsel           = (state == ST_RUN) ? run_fsel : safe_q;
  assign status_timeout = to_q;
  assign status_early   = early_q;
  assign lock_dip       = dip_q;
endmodule

// File: rtl/safe_freq_fallback.sv
module safe_freq_fallback #(
  parameter logic [sff_pkg::FSEL_W-1:0] DEFAULT_FSEL = 16'h0A5C,
  parameter int OFF_MS    = 4,
  parameter int STABLE_MS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rst_req_n,
  input  logic                       ms_tick,
  input  logic                       pll_locked,
  input  logic [1:0]                 safe_wr,
  input  logic [sff_pkg::BYTE_W-1:0] safe_lo,
  input  logic [sff_pkg::BYTE_W-1:0] safe_hi,
  input  logic [sff_pkg::FSEL_W-1:0] run_fsel,
  output logic [sff_pkg::FSEL_W-1:0] fsel,
  output logic                       clk_oe,
  output logic                       status_timeout,
  output logic                       status_early
);
  // Internal events, named for the checker.
  logic                       fall_evt, rise_evt, req_lvl;
  logic                       written, lock_dip, in_gate;
  logic [sff_pkg::FSEL_W-1:0] safe_word;

  sff_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .req_n(rst_req_n),
    .req_lvl(req_lvl), .fall(fall_evt), .rise(rise_evt)
  );

  sff_safe_store #(.NUM_BYTES(2), .DEFAULT_FSEL(DEFAULT_FSEL)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_strobe(safe_wr),
    .byte_lo(safe_lo), .byte_hi(safe_hi),
    .written(written), .safe_word(safe_word)
  );

  sff_seq_fsm #(.OFF_MS(OFF_MS), .STABLE_MS(STABLE_MS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .fall(fall_evt), .rise(rise_evt), .req_lvl(req_lvl),
    .ms_tick(ms_tick), .pll_locked(pll_locked), .safe_word(safe_word), .run_fsel(run_fsel),
    .fsel(fsel), .clk_oe(clk_oe), .status_timeout(status_timeout),
    .status_early(status_early), .lock_dip(lock_dip), .in_gate(in_gate)
  );
endmodule

// File: rtl/sff_checker.sv
module sff_checker #(
  parameter int OFF_MS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ms_tick,
  input logic        pll_locked,
  input logic        fall_evt,
  input logic        lock_dip,
  input logic        in_gate,
  input logic        clk_oe,
  input logic        status_timeout,
  input logic [15:0] fsel
);
  logic [7:0] gate_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gate_ticks <= '0;
    else if (fall_evt)       gate_ticks <= '0;
    else if (!in_gate)       gate_ticks <= '0;
    else if (ms_tick)        gate_ticks <= gate_ticks + 8'd1;
  end

  // R2: a request transition gates the outputs on the next edge
  a_r2_fall_gates: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !clk_oe);

  // R4: the gated window never spans more than OFF_MS ticks
  a_r4_bounded_window: assert property (@(posedge clk) disable iff (!rst_n)
    gate_ticks <= 8'(OFF_MS));

  // R4: a forced re-enable leaves the outputs on
  a_r4_timeout_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    status_timeout |-> clk_oe);

  // R3: the frequency word holds steady throughout the gated window
  a_r3_fsel_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (in_gate && $past(in_gate) && !$past(fall_evt)) |-> $stable(fsel));

  // R7: fresh lock re-enables without a timeout
  a_r7_lock_reenable: assert property (@(posedge clk) disable iff (!rst_n)
    (in_gate && lock_dip && pll_locked && !fall_evt) |=> (clk_oe && !status_timeout));
endmodule

bind safe_freq_fallback sff_checker #(.OFF_MS(OFF_MS)) u_sff_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pll_locked(pll_locked),
  .fall_evt(fall_evt), .lock_dip(lock_dip), .in_gate(in_gate),
  .clk_oe(clk_oe), .status_timeout(status_timeout), .fsel(fsel)
);

// File: tb/safe_freq_fallback_tb_top.sv
module safe_freq_fallback_tb_top;
  localparam int CLK_HALF = 10;
  localparam logic [15:0] DFLT = 16'h0A5C;
  localparam int OFF_MS = 4;
  localparam int STABLE_MS = 2;

  logic        clk = 1'b0;
  logic        rst_n, rst_req_n, ms_tick, pll_locked;
  logic [1:0]  safe_wr;
  logic [7:0]  safe_lo, safe_hi;
  logic [15:0] run_fsel, fsel;
  logic        clk_oe, status_timeout, status_early;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  m_written = 1'b0;
  bit  done = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  safe_freq_fallback #(.DEFAULT_FSEL(DFLT), .OFF_MS(OFF_MS), .STABLE_MS(STABLE_MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req_n(rst_req_n), .ms_tick(ms_tick),
    .pll_locked(pll_locked), .safe_wr(safe_wr), .safe_lo(safe_lo), .safe_hi(safe_hi),
    .run_fsel(run_fsel), .fsel(fsel), .clk_oe(clk_oe),
    .status_timeout(status_timeout), .status_early(status_early)
  );

  function automatic logic [15:0] exp_safe();
    return m_written ? {safe_hi, safe_lo} : DFLT;
  endfunction

  function automatic bit exp_early(int hold_ticks);
    return hold_ticks < STABLE_MS;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_tick();
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic write_bytes(logic [1:0] strobe, logic [7:0] lo, logic [7:0] hi);
    safe_lo = lo; safe_hi = hi; safe_wr = strobe;
    @(negedge clk);
    safe_wr = 2'b00;
    if (strobe != 2'b00) m_written = 1'b1;
  endtask

  task automatic start_fall(output logic [15:0] es);
    es = exp_safe();
    rst_req_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 gated after request edge", 16'(clk_oe), 16'd0);
    chk("R3 safe word while gated", fsel, es);
  endtask

  task automatic release_req(int hold_ticks);
    rst_req_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 run select restored", fsel, run_fsel);
    chk("R9 early flag", 16'(status_early), 16'(exp_early(hold_ticks)));
  endtask

  task automatic run_seq(bit use_lock, int lock_at, int hold_ticks);
    logic [15:0] es;
    bit by_lock;
    by_lock = 1'b0;
    start_fall(es);
    if (use_lock) begin
      pll_locked = 1'b0;
      @(negedge clk);
    end
    for (int t = 0; t < OFF_MS; t++) begin
      if (use_lock && lock_at == t) begin
        pll_locked = 1'b1;
        @(negedge clk);
        by_lock = 1'b1;
        break;
      end
      chk("R4 still gated before limit", 16'(clk_oe), 16'd0);
      pulse_tick();
    end
    pll_locked = 1'b1;
    chk("R4/R7 outputs re-enabled", 16'(clk_oe), 16'd1);
    chk("R4/R7 timeout flag", 16'(status_timeout), 16'(!by_lock));
    chk("R3 safe word after re-enable", fsel, es);
    for (int h = 0; h < hold_ticks; h++) pulse_tick();
    chk("R8 safe word held until release", fsel, es);
    release_req(hold_ticks);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(2 * CLK_HALF * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] es;
    void'($urandom(32'd2779));
    rst_n = 1'b0; rst_req_n = 1'b1; ms_tick = 1'b0; pll_locked = 1'b1;
    safe_wr = 2'b00; safe_lo = 8'h11; safe_hi = 8'h22; run_fsel = 16'h1234;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 enable after reset", 16'(clk_oe), 16'd1);
    chk("R1 fsel follows run", fsel, run_fsel);
    chk("R1 timeout clear", 16'(status_timeout), 16'd0);
    chk("R1 early clear", 16'(status_early), 16'd0);

    // R5 default safe word before any write, lock path
    run_seq(1'b1, 1, 2);

    // R2 holding the request low does not retrigger
    start_fall(es);
    pll_locked = 1'b0; @(negedge clk);
    pll_locked = 1'b1; @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      pulse_tick();
      chk("R2 level low keeps outputs on", 16'(clk_oe), 16'd1);
      chk("R2 level low keeps safe word", fsel, es);
    end
    release_req(3);

    // R5 write of only the high byte selects the programmed word
    write_bytes(2'b10, 8'h5A, 8'hC3);
    chk("R5 programmed word expected", exp_safe(), 16'hC35A);
    run_seq(1'b0, 0, 3);

    // R6 register changes during a fallback are ignored
    start_fall(es);
    write_bytes(2'b11, 8'h01, 8'h02);
    chk("R6 fsel unchanged by write", fsel, es);
    pll_locked = 1'b0; @(negedge clk);
    pll_locked = 1'b1; @(negedge clk);
    chk("R6 fsel unchanged after relock", fsel, es);
    release_req(0);
    chk("R5 new bytes used next time", exp_safe(), 16'h0201);

    // R7 lock beats the final tick in the same cycle
    start_fall(es);
    pll_locked = 1'b0; @(negedge clk);
    for (int i = 0; i < OFF_MS - 1; i++) pulse_tick();
    chk("R7 still gated before last tick", 16'(clk_oe), 16'd0);
    pll_locked = 1'b1; ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    chk("R7 enabled by lock", 16'(clk_oe), 16'd1);
    chk("R7 lock wins over tick", 16'(status_timeout), 16'd0);
    release_req(0);

    // R9 settling-time boundary
    run_seq(1'b1, 0, 1);
    run_seq(1'b1, 0, 2);

    // R10 restart by a second request edge
    start_fall(es);
    for (int i = 0; i < OFF_MS - 1; i++) pulse_tick();
    rst_req_n = 1'b1; @(negedge clk);
    rst_req_n = 1'b0; repeat (2) @(negedge clk);
    chk("R10 early flag cleared by restart", 16'(status_early), 16'd0);
    for (int i = 0; i < OFF_MS - 1; i++) begin
      pulse_tick();
      chk("R10 count restarted, still gated", 16'(clk_oe), 16'd0);
    end
    pulse_tick();
    chk("R10 enabled at restarted limit", 16'(clk_oe), 16'd1);
    chk("R10 timeout after restarted limit", 16'(status_timeout), 16'd1);
    rst_req_n = 1'b0; @(negedge clk);
    release_req(0);

    // Constrained random sequences
    for (int it = 0; it < 40; it++) begin
      if ($urandom_range(0, 3) == 0)
        write_bytes(2'($urandom_range(1, 3)), 8'($urandom()), 8'($urandom()));
      run_fsel = 16'($urandom());
      @(negedge clk);
      run_seq(1'($urandom_range(0, 1)), int'($urandom_range(0, 5)), int'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule